// File: doc/BRIEF.md
# Microcode Return Address Stack

This block holds return addresses for micro-subroutine linkage in a microprogrammed sequencer. It is a small register stack, 16 entries of 12 bits by default, indexed by an internal up/down pointer. The sequencer presents its location counter, which already points one past the instruction being executed. A save command stores that value in the entry under the pointer. A return command drives the entry under the pointer out as the next location, and can also store the location counter back into that same entry in the same cycle. That swap gives coroutine-style linkage.

Pointer motion is commanded separately from save and return. An increment and a decrement can each be paired with any data operation. The pointer wraps modulo the depth in both directions and no overflow or underflow is flagged. Software cannot load the pointer or read it directly. The only view into the stack is the entry currently under the pointer.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the pointer is zero, every entry reads zero and `ret_valid_o` is low.
- R2: With `save_i` high at a clock edge, the entry under the pointer takes `loc_i`. With no pointer motion, `rd_data_o` shows `loc_i` after that edge.
- R3: While `ret_i` is high, `ret_valid_o` is high and `ret_addr_o` equals the entry under the pointer in that same cycle, with no added latency.
- R4: With `ret_i` and `swap_i` both high at an edge, `ret_addr_o` shows the old entry during the cycle, and the entry holds `loc_i` after the edge.
- R5: A return without `swap_i` leaves the entry it reads unchanged.
- R6: `ptr_up_i` alone moves the pointer up by one at the edge, and `ptr_dn_i` alone moves it down by one. Either can be combined with save or return.
- R7: The pointer wraps from the last entry to entry 0 going up, and from entry 0 to the last entry going down.
- R8: When a write and a pointer move happen at the same edge, the write goes to the entry under the pointer from before the move.
- R9: With `ptr_up_i` and `ptr_dn_i` both high, the pointer does not move.
- R10: `swap_i` without `ret_i` writes nothing. With no save, no swap-return and no pointer motion, `rd_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| save_i | input | 1 | Store `loc_i` into the current entry |
| ret_i | input | 1 | Return: drive the current entry out as the next location |
| swap_i | input | 1 | Together with `ret_i`, store `loc_i` into the entry being returned from |
| ptr_up_i | input | 1 | Increment the pointer |
| ptr_dn_i | input | 1 | Decrement the pointer |
| loc_i | input | 12 | Incremented location counter |
| rd_data_o | output | 12 | Entry under the pointer |
| ret_valid_o | output | 1 | A return target is being driven |
| ret_addr_o | output | 12 | Return target, valid while `ret_valid_o` is high |

## Verification
The main stimulus is a sequence of mixed commands. It pairs saves and swap-returns with increments, decrements, both motions at once, and no motion. A write that lands in the wrong entry, relative to the pointer before or after a move, then shows up as a wrong `rd_data_o` value after a later move. Plain returns are compared against swap-returns, and swap is also asserted without return, to separate the write enable from the read path. Walks past entry 0 in both directions expose any wrap fault. A reset in the middle of the run, taken after data has been written, shows whether both the pointer and the entries clear.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  parameter int unsigned LOC_W = 12;
  parameter int unsigned DEPTH = 16;
  localparam int unsigned PTR_W = $clog2(DEPTH);

  typedef enum logic [1:0] {
    MOVE_HOLD = 2'b00,
    MOVE_UP   = 2'b01,
    MOVE_DN   = 2'b10
  } move_e;
endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH_P = DEPTH,
  localparam int unsigned PW = $clog2(DEPTH_P)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          up_i,
  input  logic          dn_i,
  output logic [PW-1:0] ptr_o
);
  move_e         move;
  logic [PW-1:0] ptr_q;

  always_comb begin
    unique case ({dn_i, up_i})
      2'b01:   move = MOVE_UP;
      2'b10:   move = MOVE_DN;
      default: move = MOVE_HOLD; // both high cancel
    endcase
  end

  // DEPTH_P is a power of two, so wrap is plain overflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else begin
      unique case (move)
        MOVE_UP: ptr_q <= ptr_q + PW'(1);
        MOVE_DN: ptr_q <= ptr_q - PW'(1);
        default: ptr_q <= ptr_q;
      endcase
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/rstk_regs.sv
module rstk_regs
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH_P = DEPTH,
  parameter int unsigned W_P     = LOC_W,
  localparam int unsigned PW = $clog2(DEPTH_P)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] idx_i,
  input  logic [W_P-1:0] wdata_i,
  output logic [W_P-1:0] rdata_o
);
  logic [W_P-1:0] mem_q [DEPTH_P];

  for (genvar g = 0; g < DEPTH_P; g++) begin : g_ent
    logic sel;
    assign sel = we_i && (idx_i == PW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mem_q[g] <= '0;
      else if (sel) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH_P = DEPTH,
  parameter int unsigned W_P     = LOC_W,
  localparam int unsigned PW = $clog2(DEPTH_P)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           save_i,
  input  logic           ret_i,
  input  logic           swap_i,
  input  logic           ptr_up_i,
  input  logic           ptr_dn_i,
  input  logic [W_P-1:0] loc_i,
  output logic [W_P-1:0] rd_data_o,
  output logic           ret_valid_o,
  output logic [W_P-1:0] ret_addr_o
);
  logic [PW-1:0]  ptr_q;
  logic [W_P-1:0] cur;
  logic           wr_en;

  // write uses the pointer from before this edge's move
  assign wr_en = save_i || (ret_i && swap_i);

  rstk_ptr #(.DEPTH_P(DEPTH_P)) i_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .up_i  (ptr_up_i),
    .dn_i  (ptr_dn_i),
    .ptr_o (ptr_q)
  );

  rstk_regs #(.DEPTH_P(DEPTH_P), .W_P(W_P)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en),
    .idx_i  (ptr_q),
    .wdata_i(loc_i),
    .rdata_o(cur)
  );

  assign rd_data_o   = cur;
  assign ret_valid_o = ret_i;
  assign ret_addr_o  = ret_i ? cur : '0;
endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
  parameter int unsigned W_P = 12,
  parameter int unsigned PW  = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           save_i,
  input logic           ret_i,
  input logic           swap_i,
  input logic           ptr_up_i,
  input logic           ptr_dn_i,
  input logic [W_P-1:0] loc_i,
  input logic [W_P-1:0] rd_data_o,
  input logic           ret_valid_o,
  input logic [W_P-1:0] ret_addr_o,
  input logic [PW-1:0]  ptr_q
);
  logic wr, still;
  assign wr    = save_i || (ret_i && swap_i);
  assign still = !ptr_up_i && !ptr_dn_i;

  AST_PTR_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_up_i && !ptr_dn_i) |=> ptr_q == $past(ptr_q) + PW'(1)); // R6
  AST_PTR_DN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_dn_i && !ptr_up_i && ptr_q == '0) |=> ptr_q == '1); // R7
  AST_PTR_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_up_i && ptr_dn_i) |=> $stable(ptr_q)); // R9
  AST_SAVE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && still) |=> rd_data_o == $past(loc_i)); // R2
  AST_SWAP_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && swap_i && still) |=> rd_data_o == $past(loc_i)); // R4
  AST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr && still) |=> $stable(rd_data_o)); // R10
  AST_RET_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> ret_addr_o == rd_data_o); // R3
endmodule

bind ret_addr_stack ret_addr_stack_chk #(.W_P(W_P), .PW(PW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .save_i     (save_i),
  .ret_i      (ret_i),
  .swap_i     (swap_i),
  .ptr_up_i   (ptr_up_i),
  .ptr_dn_i   (ptr_dn_i),
  .loc_i      (loc_i),
  .rd_data_o  (rd_data_o),
  .ret_valid_o(ret_valid_o),
  .ret_addr_o (ret_addr_o),
  .ptr_q      (ptr_q)
);

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        save = 1'b0, ret = 1'b0, swap = 1'b0, up = 1'b0, dn = 1'b0;
  logic [11:0] loc = '0;
  logic [11:0] rd_data, ret_addr;
  logic        ret_valid;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ret_addr_stack i_ret_addr_stack (
    .clk_i(clk), .rst_ni(rst_n), .save_i(save), .ret_i(ret), .swap_i(swap),
    .ptr_up_i(up), .ptr_dn_i(dn), .loc_i(loc),
    .rd_data_o(rd_data), .ret_valid_o(ret_valid), .ret_addr_o(ret_addr)
  );

  // {req, save, ret, swap, up, dn, loc, exp_ret_addr, exp_rd_after}
  localparam int NV = 14;
  localparam logic [44:0] VEC [NV] = '{
    {4'd2,  5'b10000, 12'h101, 12'h000, 12'h101}, // R2 save at ptr 0
    {4'd6,  5'b00010, 12'h000, 12'h000, 12'h000}, // R6 up to 1
    {4'd8,  5'b10010, 12'h202, 12'h000, 12'h000}, // R8 save at 1, move to 2
    {4'd6,  5'b00001, 12'h000, 12'h000, 12'h202}, // R6 down to 1
    {4'd5,  5'b01000, 12'h333, 12'h202, 12'h202}, // R5 plain return, R3
    {4'd4,  5'b01100, 12'h344, 12'h202, 12'h344}, // R4 swap-return
    {4'd9,  5'b10011, 12'h355, 12'h000, 12'h355}, // R9 cancel with save
    {4'd10, 5'b00100, 12'h366, 12'h000, 12'h355}, // R10 swap alone
    {4'd6,  5'b00001, 12'h000, 12'h000, 12'h101}, // R6 down to 0
    {4'd7,  5'b00001, 12'h000, 12'h000, 12'h000}, // R7 wrap to 15
    {4'd2,  5'b10000, 12'hABC, 12'h000, 12'hABC}, // R2 save at 15
    {4'd7,  5'b00010, 12'h000, 12'h000, 12'h101}, // R7 wrap to 0
    {4'd8,  5'b01101, 12'h777, 12'h101, 12'hABC}, // R8 swap at 0, move to 15
    {4'd3,  5'b00010, 12'h000, 12'h000, 12'h777}  // R3 up to 0
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    {save, ret, swap, up, dn} = 5'b0;
    loc = '0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #3;
    check("R1", rd_data, 12'h000);
    check("R1", {11'b0, ret_valid}, 12'h000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] req;
      req = VEC[i][44:41];
      @(negedge clk);
      {save, ret, swap, up, dn} = VEC[i][40:36];
      loc = VEC[i][35:24];
      #1;
      if (ret) begin
        check($sformatf("R%0d ret", req), ret_addr, VEC[i][23:12]);
        check($sformatf("R%0d valid", req), {11'b0, ret_valid}, 12'h001);
      end
      @(posedge clk); #1;
      check($sformatf("R%0d rd", req), rd_data, VEC[i][11:0]);
      idle();
    end

    // R1: reset mid-run clears pointer and entries
    @(negedge clk); rst_n = 1'b0;
    #1; check("R1 rd after reset", rd_data, 12'h000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); up = 1'b1;
    @(posedge clk); #1; idle();
    check("R1 entry1 cleared", rd_data, 12'h000);
    @(negedge clk); dn = 1'b1;
    @(posedge clk); #1; idle();
    check("R1 entry0 cleared", rd_data, 12'h000);
    // R3: no return, valid low
    #1; check("R3 valid low", {11'b0, ret_valid}, 12'h000);

    // R7: full walk up returns to the saved entry
    @(negedge clk); save = 1'b1; loc = 12'h5A5;
    @(posedge clk); #1; idle();
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); up = 1'b1;
      @(posedge clk); #1; idle();
    end
    check("R7 walk 16 up", rd_data, 12'h5A5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule